// File: doc/BRIEF.md
# Sorted Price-Level Order Store

This block keeps the resting orders of one side of one instrument's book in on-chip storage, and keeps them in rank order at all times. Every order is a record of a price, a quantity and a 64-bit order reference. When a new order comes in, the block finds its place in the ranking and moves every lower-ranked record down one slot. It then writes the new record into the slot that is now free. Because of this, the store never needs a separate sort pass.

A single command port accepts two operations: insert one order, or read the whole book out. The read-out sends every stored record as a stream, one record per clock cycle, best rank first. The final record carries a flag that marks it as last. While an insertion or a read-out is running, the command port holds its ready low. An insert that arrives when the store is full is refused, and the block reports this with a one-cycle error pulse. The default capacity is 1000 records. By default the ranking is highest price first, which is the ordering for buy interest. A parameter reverses the price comparison for a sell-side book.

Top module: `order_book_sorted`

## Requirements
- R1: After a synchronous active-low reset, `cmd_ready` is 1, `out_valid` is 0 and `err_full` is 0. The store holds no records, so a read-out returns the empty beat.
- R2: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_op` = 0 means insert the order on `cmd_price`/`cmd_qty`/`cmd_ref`. `cmd_op` = 1 means read out the whole book.
- R3: With the default ranking, the read-out gives records in non-increasing price order.
- R4: Records of equal price come out in the order they were inserted, earliest first.
- R5: In the cycle after an insert is taken into a store that is not full, `cmd_ready` is 0. It returns to 1 once the record is placed.
- R6: At capacity (`DEPTH` records), an insert is taken but refused. `err_full` is 1 for exactly the next cycle, `cmd_ready` stays 1 and the stored contents do not change.
- R7: A read-out of N > 0 records gives N consecutive `out_valid` beats. `out_last` is set only on the Nth beat, and `cmd_ready` is 0 until the last beat. A read-out does not change the contents, so a second read-out repeats the first.
- R8: A read-out of an empty store gives exactly one beat with `out_valid`, `out_empty` and `out_last` all set and with zero data fields.
- R9: Every beat carries the price, quantity and reference of one inserted order, unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 1 | 0 = insert order, 1 = read out book |
| cmd_price | input | 32 | Price of the order to insert |
| cmd_qty | input | 32 | Quantity of the order to insert |
| cmd_ref | input | 64 | Order reference of the order to insert |
| out_valid | output | 1 | Read-out beat present |
| out_last | output | 1 | Final beat of a read-out |
| out_empty | output | 1 | Beat reports an empty store |
| out_price | output | 32 | Price of the beat's record |
| out_qty | output | 32 | Quantity of the beat's record |
| out_ref | output | 64 | Reference of the beat's record |
| err_full | output | 1 | One-cycle pulse: insert refused, store full |

## Verification
The bench builds its own expected ranking by modelling insertion sort. It compares the stream against that ranking after a mixed sequence in which new orders land at the head, in the middle and at the tail. That sequence also contains repeated prices, so a fault in scan position or in tie order shows up. A second pattern gives strictly rising prices: every insert then goes to the head, and the shift has to move the whole store each time. This separates a correct shift loop from one that stops early or moves the wrong way. Directed cases cover the empty read-out, a refused insert at capacity followed by an unchanged read-out, and a repeated read-out. A reset in the middle of a run must bring back the empty store.

// File: rtl/obk_pkg.sv
package obk_pkg;
   localparam int PRICE_W = 32;
   localparam int QTY_W   = 32;
   localparam int REF_W   = 64;

   typedef struct packed {
      logic [PRICE_W-1:0] price;
      logic [QTY_W-1:0]   qty;
      logic [REF_W-1:0]   oref;
   } entry_t;

   localparam int ENTRY_W = $bits(entry_t);

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SCAN,
      ST_SHIFT,
      ST_DUMP
   } state_t;

   localparam logic OP_ADD  = 1'b0;
   localparam logic OP_DUMP = 1'b1;
endpackage

// File: rtl/obk_store.sv
module obk_store
   import obk_pkg::*;
#(
   parameter int DEPTH = 1000,
   parameter int AW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  entry_t        wdata,
   input  logic [AW-1:0] raddr,
   output entry_t        rdata
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

   entry_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && (waddr <= TOP)) begin
         mem[waddr[IW-1:0]] <= wdata;
      end
   end

   always_comb begin
      if (raddr <= TOP) begin
         rdata = mem[raddr[IW-1:0]];
      end else begin
         rdata = '0;
      end
   end
endmodule

// File: rtl/obk_cmp.sv
module obk_cmp
   import obk_pkg::*;
#(
   parameter bit DESCENDING = 1'b1
) (
   input  logic [PRICE_W-1:0] new_price,
   input  logic [PRICE_W-1:0] old_price,
   output logic               ranks_ahead
);
   generate
      if (DESCENDING) begin : g_high_first
         assign ranks_ahead = new_price > old_price;
      end else begin : g_low_first
         assign ranks_ahead = new_price < old_price;
      end
   endgenerate
endmodule

// File: rtl/obk_ctrl.sv
module obk_ctrl
   import obk_pkg::*;
#(
   parameter int DEPTH = 1000,
   parameter int AW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic          cmd_op,
   input  entry_t        cmd_entry,
   output logic          cmd_ready,
   output logic [AW-1:0] mem_raddr,
   input  entry_t        mem_rdata,
   output logic          mem_we,
   output logic [AW-1:0] mem_waddr,
   output entry_t        mem_wdata,
   output entry_t        pend_entry,
   input  logic          ranks_ahead,
   output logic          out_valid,
   output logic          out_last,
   output logic          out_empty,
   output entry_t        out_entry,
   output logic          err_full
);
   localparam logic [AW-1:0] CAP = AW'(DEPTH);

   state_t        state;
   logic [AW-1:0] cnt;
   logic [AW-1:0] idx;
   logic [AW-1:0] pos;
   entry_t        pend;

   assign cmd_ready  = (state == ST_IDLE);
   assign pend_entry = pend;

   always_comb begin
      mem_raddr = idx;
      if (state == ST_SHIFT) begin
         mem_raddr = idx - 1'b1;
      end
   end

   assign mem_we    = (state == ST_SHIFT);
   assign mem_waddr = idx;
   assign mem_wdata = (idx == pos) ? pend : mem_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         idx       <= '0;
         pos       <= '0;
         pend      <= '0;
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_empty <= 1'b0;
         out_entry <= '0;
         err_full  <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_empty <= 1'b0;
         err_full  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (cmd_valid && cmd_op == OP_ADD) begin
                  if (cnt == CAP) begin
                     err_full <= 1'b1;
                  end else begin
                     pend  <= cmd_entry;
                     idx   <= '0;
                     state <= ST_SCAN;
                  end
               end else if (cmd_valid && cmd_op == OP_DUMP) begin
                  if (cnt == '0) begin
                     out_valid <= 1'b1;
                     out_last  <= 1'b1;
                     out_empty <= 1'b1;
                     out_entry <= '0;
                  end else begin
                     idx   <= '0;
                     state <= ST_DUMP;
                  end
               end
            end
            ST_SCAN: begin
               if (idx == cnt || ranks_ahead) begin
                  pos   <= idx;
                  idx   <= cnt;
                  state <= ST_SHIFT;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_SHIFT: begin
               if (idx == pos) begin
                  cnt   <= cnt + 1'b1;
                  state <= ST_IDLE;
               end else begin
                  idx <= idx - 1'b1;
               end
            end
            ST_DUMP: begin
               out_valid <= 1'b1;
               out_entry <= mem_rdata;
               if (idx == cnt - 1'b1) begin
                  out_last <= 1'b1;
                  state    <= ST_IDLE;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/order_book_sorted.sv
module order_book_sorted
   import obk_pkg::*;
#(
   parameter int DEPTH      = 1000,
   parameter bit DESCENDING = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic               cmd_op,
   input  logic [PRICE_W-1:0] cmd_price,
   input  logic [QTY_W-1:0]   cmd_qty,
   input  logic [REF_W-1:0]   cmd_ref,
   output logic               out_valid,
   output logic               out_last,
   output logic               out_empty,
   output logic [PRICE_W-1:0] out_price,
   output logic [QTY_W-1:0]   out_qty,
   output logic [REF_W-1:0]   out_ref,
   output logic               err_full
);
   localparam int AW = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 2) else $error("order_book_sorted: DEPTH must be at least 2");
      assert (ENTRY_W == PRICE_W + QTY_W + REF_W) else $error("order_book_sorted: entry width mismatch");
   end

   entry_t        cmd_entry;
   entry_t        rd_entry;
   entry_t        wr_entry;
   entry_t        pend_entry;
   entry_t        out_entry;
   logic [AW-1:0] raddr;
   logic [AW-1:0] waddr;
   logic          we;
   logic          ranks_ahead;

   assign cmd_entry = '{price: cmd_price, qty: cmd_qty, oref: cmd_ref};
   assign out_price = out_entry.price;
   assign out_qty   = out_entry.qty;
   assign out_ref   = out_entry.oref;

   obk_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wr_entry),
      .raddr (raddr),
      .rdata (rd_entry)
   );

   obk_cmp #(.DESCENDING(DESCENDING)) u_cmp (
      .new_price   (pend_entry.price),
      .old_price   (rd_entry.price),
      .ranks_ahead (ranks_ahead)
   );

   obk_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_op      (cmd_op),
      .cmd_entry   (cmd_entry),
      .cmd_ready   (cmd_ready),
      .mem_raddr   (raddr),
      .mem_rdata   (rd_entry),
      .mem_we      (we),
      .mem_waddr   (waddr),
      .mem_wdata   (wr_entry),
      .pend_entry  (pend_entry),
      .ranks_ahead (ranks_ahead),
      .out_valid   (out_valid),
      .out_last    (out_last),
      .out_empty   (out_empty),
      .out_entry   (out_entry),
      .err_full    (err_full)
   );
endmodule

// File: rtl/obk_chk.sv
module obk_chk
   import obk_pkg::*;
#(
   parameter int DEPTH      = 1000,
   parameter bit DESCENDING = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic               cmd_ready,
   input logic               cmd_op,
   input logic               out_valid,
   input logic               out_last,
   input logic               out_empty,
   input logic [PRICE_W-1:0] out_price,
   input logic               err_full
);
   localparam int AW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] CAP = AW'(DEPTH);

   logic [AW-1:0] shadow;
   logic          take_add;
   logic          take_dump;

   assign take_add  = cmd_valid && cmd_ready && cmd_op == OP_ADD;
   assign take_dump = cmd_valid && cmd_ready && cmd_op == OP_DUMP;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
      end else if (take_add && shadow != CAP) begin
         shadow <= shadow + 1'b1;
      end
   end

   // R5: a placed insert makes the port busy on the next cycle
   p_busy_after_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take_add && shadow != CAP |=> !cmd_ready);

   // R6: insert at capacity is refused with a pulse and the port stays free
   p_full_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take_add && shadow == CAP |=> err_full && cmd_ready);

   // R6: the error pulse appears only at capacity
   p_err_only_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_full |-> shadow == CAP);

   // R7: a non-empty read-out makes the port busy
   p_busy_after_dump_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_dump && shadow != '0 |=> !cmd_ready);

   // R7: beats before the last are back to back with the port busy
   p_stream_gapless_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_last |=> out_valid);

   p_stream_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_last |-> !cmd_ready);

   // R8: the empty beat is a single, final beat
   p_empty_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_empty |-> out_valid && out_last && out_price == '0);

   // R3: consecutive beats follow the ranking
   generate
      if (DESCENDING) begin : g_ord_desc
         p_rank_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && !out_last |=> out_price <= $past(out_price));
      end else begin : g_ord_asc
         p_rank_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && !out_last |=> out_price >= $past(out_price));
      end
   endgenerate
endmodule

bind order_book_sorted obk_chk #(.DEPTH(DEPTH), .DESCENDING(DESCENDING)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .out_valid (out_valid),
   .out_last  (out_last),
   .out_empty (out_empty),
   .out_price (out_price),
   .err_full  (err_full)
);

// File: tb/tb_order_book_sorted.sv
module tb_order_book_sorted;
   localparam int DEPTH = 8;
   localparam int NVEC  = 8;

   // each vector: {price, qty, ref}
   localparam logic [127:0] VEC [NVEC] = '{
      {32'd100, 32'd10, 64'h1001},
      {32'd200, 32'd20, 64'h1002},
      {32'd100, 32'd11, 64'h1003},
      {32'd50,  32'd5,  64'h1004},
      {32'd300, 32'd30, 64'h1005},
      {32'd200, 32'd21, 64'h1006},
      {32'd100, 32'd12, 64'h1007},
      {32'd400, 32'd40, 64'h1008}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_op = 1'b0;
   logic [31:0] cmd_price = '0;
   logic [31:0] cmd_qty = '0;
   logic [63:0] cmd_ref = '0;
   logic        out_valid, out_last, out_empty, err_full;
   logic [31:0] out_price, out_qty;
   logic [63:0] out_ref;

   always #2.5 clk = ~clk;

   order_book_sorted #(.DEPTH(DEPTH), .DESCENDING(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_price(cmd_price), .cmd_qty(cmd_qty), .cmd_ref(cmd_ref),
      .out_valid(out_valid), .out_last(out_last), .out_empty(out_empty),
      .out_price(out_price), .out_qty(out_qty), .out_ref(out_ref), .err_full(err_full)
   );

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   logic [31:0] m_price [DEPTH];
   logic [31:0] m_qty   [DEPTH];
   logic [63:0] m_ref   [DEPTH];
   int          m_cnt = 0;

   logic [31:0] g_price [DEPTH+2];
   logic [31:0] g_qty   [DEPTH+2];
   logic [63:0] g_ref   [DEPTH+2];
   int          g_n;
   bit          g_empty;
   bit          g_busy_bad;
   bit          last_err;
   bit          last_ready;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_add(input logic [31:0] p, input logic [31:0] q, input logic [63:0] r);
      int at;
      if (m_cnt >= DEPTH) return;
      at = m_cnt;
      for (int i = 0; i < m_cnt; i++) begin
         if (m_price[i] < p) begin
            at = i;
            break;
         end
      end
      for (int i = m_cnt; i > at; i--) begin
         m_price[i] = m_price[i-1];
         m_qty[i]   = m_qty[i-1];
         m_ref[i]   = m_ref[i-1];
      end
      m_price[at] = p;
      m_qty[at]   = q;
      m_ref[at]   = r;
      m_cnt++;
   endtask

   task automatic wait_ready();
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
   endtask

   task automatic send_add(input logic [31:0] p, input logic [31:0] q, input logic [63:0] r);
      wait_ready();
      cmd_valid = 1'b1;
      cmd_op    = 1'b0;
      cmd_price = p;
      cmd_qty   = q;
      cmd_ref   = r;
      @(negedge clk);
      cmd_valid  = 1'b0;
      last_err   = err_full;
      last_ready = cmd_ready;
      model_add(p, q, r);
   endtask

   task automatic do_dump();
      bit done;
      done = 1'b0;
      g_n = 0;
      g_empty = 1'b0;
      g_busy_bad = 1'b0;
      wait_ready();
      cmd_valid = 1'b1;
      cmd_op    = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int k = 0; k < DEPTH + 4 && !done; k++) begin
         if (out_valid) begin
            if (g_n < DEPTH + 2) begin
               g_price[g_n] = out_price;
               g_qty[g_n]   = out_qty;
               g_ref[g_n]   = out_ref;
            end
            g_n++;
            if (out_empty) g_empty = 1'b1;
            if (!out_last && cmd_ready) g_busy_bad = 1'b1;
            if (out_last) done = 1'b1;
         end
         if (!done) @(negedge clk);
      end
   endtask

   task automatic verify_dump(input string req);
      check(g_n == m_cnt, "R7", {req, " beat count"}, g_n, m_cnt);
      check(!g_busy_bad, "R7", {req, " ready low during stream"}, g_busy_bad, 0);
      for (int i = 0; i < m_cnt && i < g_n; i++) begin
         check(g_price[i] == m_price[i], req, $sformatf("price slot %0d", i), g_price[i], m_price[i]);
         check(g_ref[i] == m_ref[i], "R4", $sformatf("ref slot %0d", i), g_ref[i], m_ref[i]);
         check(g_qty[i] == m_qty[i], "R9", $sformatf("qty slot %0d", i), g_qty[i], m_qty[i]);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state during and after reset
      check(cmd_ready == 1'b1, "R1", "cmd_ready in reset", cmd_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(err_full == 1'b0, "R1", "err_full after reset", err_full, 0);

      // R8: empty read-out
      do_dump();
      check(g_n == 1 && g_empty, "R8", "empty beat count", g_n, 1);
      check(g_price[0] == 0 && g_ref[0] == 0, "R8", "empty beat data", g_ref[0], 0);

      // table walk: mixed head, middle, tail and tie inserts (R2, R3, R4, R5)
      for (int v = 0; v < NVEC; v++) begin
         send_add(VEC[v][127:96], VEC[v][95:64], VEC[v][63:0]);
         check(last_ready == 1'b0, "R5", "busy after insert", last_ready, 0);
         check(last_err == 1'b0, "R6", "no error below capacity", last_err, 0);
      end
      do_dump();
      verify_dump("R3");

      // R6: refused insert at capacity, contents unchanged
      send_add(32'd999, 32'd9, 64'hDEAD);
      m_cnt = DEPTH;
      for (int i = 0; i < DEPTH; i++) begin
         m_price[i] = m_price[i];
      end
      check(last_err == 1'b1, "R6", "err_full pulse", last_err, 1);
      check(last_ready == 1'b1, "R6", "ready stays high", last_ready, 1);
      @(negedge clk);
      check(err_full == 1'b0, "R6", "err_full single cycle", err_full, 0);
      do_dump();
      verify_dump("R6");

      // R7: second read-out repeats the first
      do_dump();
      verify_dump("R7");

      // R1: reset mid-run empties the store
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m_cnt = 0;
      do_dump();
      check(g_n == 1 && g_empty, "R1", "empty after reset", g_n, 1);

      // rising prices: each insert goes to the head and shifts all (R3)
      for (int v = 0; v < 6; v++) begin
         send_add(32'(10 + v), 32'(v), 64'(64'h2000 + v));
      end
      do_dump();
      verify_dump("R3");

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule